// File: doc/BRIEF.md
# Write Operation Status Flag Generator

This block sits in the read path of a flash-style memory. While an embedded program or chip-erase algorithm runs, it replaces array contents with status flags, so that a host can poll for completion without any other signal. It latches the operation type and the word being programmed when the operation starts. It watches each read access strobe and returns a registered read word one cycle after the strobe. It also drives an open-drain ready/busy line.

The host can detect that the operation has finished in three ways. It can read the polled bit until it shows the true data value. It can read twice and see that the toggle bit has stopped changing. It can wait for the ready/busy line to be released. At the moment the embedded algorithm signals completion, the block stops producing status and passes array data straight through. A read that lands in that same cycle already returns the real word.

Top module: `wsf_status_gen`

## Requirements
- R1: While idle, a read strobe returns the `array_data` word presented in the strobe cycle on `rd_data`, one clock after the strobe.
- R2: While a program operation is busy, bit 7 of a status read is the complement of bit 7 of the word latched at `op_start`.
- R3: While a chip erase is busy (`op_kind` = 1; 0 means program), bit 7 of a status read is 0. Once the erase has completed, reads return array data, so an erased word shows bit 7 = 1.
- R4: Bit 6 of a status read is 1 on the first read of an operation and inverts on each later status read. Cycles without a read strobe do not advance it.
- R5: During a status read, every bit of `rd_data` other than bits 7 and 6 is 0.
- R6: `ready_o` goes low in the clock after an accepted `op_start` and goes high in the clock after `op_done`. `rb_pull_o` is always the inverse of `ready_o`, meaning the open-drain pin is pulled low while busy.
- R7: A read strobe in the same cycle as `op_done` returns array data, not status. `rd_data` keeps its value in cycles without a read strobe.
- R8: An `op_start` while busy is ignored: the operation type, the latched bit 7 and the toggle sequence all continue unchanged.
- R9: Synchronous reset clears `rd_data` to 0, sets `ready_o` to 1 and abandons any operation in progress. After reset, reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Embedded operation begins (one-cycle pulse) |
| op_kind | input | 1 | 0 = program, 1 = chip erase |
| op_data | input | DW | Word being programmed |
| op_done | input | 1 | Embedded algorithm finished (one-cycle pulse) |
| rd_strobe | input | 1 | One read access (chip-enable or output-enable strobe) |
| array_data | input | DW | Array word at the read address |
| rd_data | output | DW | Registered read word |
| ready_o | output | 1 | 1 = ready, 0 = busy |
| rb_pull_o | output | 1 | Open-drain enable; 1 pulls the ready/busy pin low |

## Verification
The bench checks both values of the programmed bit 7. A design that failed to complement it would report completion from the first poll. It reads in the exact cycle of `op_done`, where a design that let status win would leave the host polling one extra time. It issues a second `op_start` in mid-operation and checks that the polled bit and the toggle phase survive; a design that relatched here would report the wrong flag or restart the toggle at 1. It also leaves idle gaps between reads, which exposes a toggle that runs on the clock instead of on read strobes.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;
endpackage

// File: rtl/wsf_op_tracker.sv
module wsf_op_tracker
  import wsf_pkg::*;
#(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  logic          op_kind,
  input  logic [DW-1:0] op_data,
  input  logic          op_done,
  output logic          busy_o,
  output op_kind_e      kind_o,
  output logic          poll_src_o
);
  logic     busy_q;
  op_kind_e kind_q;
  logic     poll_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      kind_q <= OP_PROGRAM;
      poll_q <= 1'b0;
    end else if (busy_q) begin
      if (op_done) busy_q <= 1'b0;
    end else if (op_start) begin
      busy_q <= 1'b1;
      kind_q <= op_kind_e'(op_kind);
      poll_q <= op_data[POLL_BIT];
    end
  end

  assign busy_o     = busy_q;
  assign kind_o     = kind_q;
  assign poll_src_o = poll_q;
endmodule

// File: rtl/wsf_toggle_gen.sv
module wsf_toggle_gen (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst || clear) tog_q <= 1'b0;
    else if (step)    tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/wsf_read_mux.sv
module wsf_read_mux
  import wsf_pkg::*;
#(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_strobe,
  input  logic          status_en,
  input  op_kind_e      kind,
  input  logic          poll_src,
  input  logic          tog,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] status_word;
  logic [DW-1:0] rd_q;

  always_comb begin
    status_word           = '0;
    status_word[POLL_BIT] = (kind == OP_ERASE) ? 1'b0 : ~poll_src;
    status_word[TOG_BIT]  = ~tog;
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_q <= '0;
    else if (rd_strobe) rd_q <= status_en ? status_word : array_data;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/wsf_status_gen.sv
module wsf_status_gen
  import wsf_pkg::*;
#(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  logic          op_kind,
  input  logic [DW-1:0] op_data,
  input  logic          op_done,
  input  logic          rd_strobe,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          ready_o,
  output logic          rb_pull_o
);
  logic     busy;
  op_kind_e kind;
  logic     poll_src;
  logic     tog;
  logic     status_rd;
  logic     accept;

  // completion takes priority over a read in the same cycle
  assign status_rd = rd_strobe & busy & ~op_done;
  assign accept    = op_start & ~busy;

  wsf_op_tracker #(.DW(DW), .POLL_BIT(POLL_BIT)) u_track (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .op_data(op_data), .op_done(op_done), .busy_o(busy),
    .kind_o(kind), .poll_src_o(poll_src)
  );

  wsf_toggle_gen u_tog (
    .clk(clk), .rst(rst), .clear(accept), .step(status_rd), .tog_o(tog)
  );

  wsf_read_mux #(.DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_mux (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .status_en(status_rd),
    .kind(kind), .poll_src(poll_src), .tog(tog),
    .array_data(array_data), .rd_data(rd_data)
  );

  assign ready_o   = ~busy;
  assign rb_pull_o = busy;
endmodule

// File: rtl/wsf_status_gen_chk.sv
module wsf_status_gen_chk #(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          op_start,
  input logic          op_done,
  input logic          rd_strobe,
  input logic [DW-1:0] array_data,
  input logic [DW-1:0] rd_data,
  input logic          ready_o,
  input logic          rb_pull_o
);
  localparam logic [DW-1:0] FLAG_MASK = ~((DW'(1) << POLL_BIT) | (DW'(1) << TOG_BIT));

  // R6
  busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    (op_start && ready_o) |=> !ready_o);
  // R6
  ready_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (op_done && !ready_o) |=> ready_o);
  // R6
  pin_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    rb_pull_o == !ready_o);
  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && ready_o) |=> rd_data == $past(array_data));
  // R5
  flag_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !ready_o && !op_done) |=> (rd_data & FLAG_MASK) == '0);
  // R7
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(rd_data));
endmodule

bind wsf_status_gen wsf_status_gen_chk #(.DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_chk (
  .clk(clk), .rst(rst), .op_start(op_start), .op_done(op_done),
  .rd_strobe(rd_strobe), .array_data(array_data), .rd_data(rd_data),
  .ready_o(ready_o), .rb_pull_o(rb_pull_o)
);

// File: tb/wsf_status_gen_bench.sv
module wsf_status_gen_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_start = 1'b0;
  logic          op_kind = 1'b0;
  logic [DW-1:0] op_data = '0;
  logic          op_done = 1'b0;
  logic          rd_strobe = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] rd_data;
  logic          ready_o;
  logic          rb_pull_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  wsf_status_gen u_wsf_status_gen (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .op_data(op_data), .op_done(op_done), .rd_strobe(rd_strobe),
    .array_data(array_data), .rd_data(rd_data), .ready_o(ready_o),
    .rb_pull_o(rb_pull_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input logic [DW-1:0] arr);
    rd_strobe = 1'b1; array_data = arr;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic start_op(input logic kind, input logic [DW-1:0] d);
    op_start = 1'b1; op_kind = kind; op_data = d;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic finish_op();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(2); rst = 1'b0;
    check("R9 rd_data", rd_data, '0);
    check("R9 ready", DW'(ready_o), DW'(1));
    check("R6 pull", DW'(rb_pull_o), DW'(0));
  endtask

  task automatic t_idle_read();
    do_read(16'h1234);
    check("R1 idle read", rd_data, 16'h1234);
    array_data = 16'hBEEF; idle(3);
    check("R7 hold", rd_data, 16'h1234);
  endtask

  task automatic t_program_hi();
    start_op(1'b0, 16'h00A5);
    check("R6 busy", DW'(ready_o), DW'(0));
    check("R6 pull low", DW'(rb_pull_o), DW'(1));
    do_read(16'hFFFF);
    check("R2 R4 R5 read1", rd_data, 16'h0040);
    idle(4);
    do_read(16'hFFFF);
    check("R2 R4 read2", rd_data, 16'h0000);
    do_read(16'hFFFF);
    check("R4 read3", rd_data, 16'h0040);
    finish_op();
    check("R6 ready", DW'(ready_o), DW'(1));
    do_read(16'h00A5);
    check("R2 done data", rd_data, 16'h00A5);
  endtask

  task automatic t_program_lo();
    start_op(1'b0, 16'hFF42);
    do_read(16'hFFFF);
    check("R2 bit7 low", rd_data, 16'h00C0);
    finish_op();
    do_read(16'hFF42);
    check("R2 done", rd_data, 16'hFF42);
  endtask

  task automatic t_erase();
    start_op(1'b1, 16'hFFFF);
    do_read(16'hFFFF);
    check("R3 erase busy", rd_data, 16'h0040);
    do_read(16'hFFFF);
    check("R3 R4 erase busy2", rd_data, 16'h0000);
    finish_op();
    do_read(16'hFFFF);
    check("R3 erased", rd_data, 16'hFFFF);
  endtask

  task automatic t_done_same_cycle();
    start_op(1'b0, 16'h0000);
    do_read(16'hFFFF);
    check("R2 pre", rd_data, 16'h00C0);
    rd_strobe = 1'b1; op_done = 1'b1; array_data = 16'h5A5A;
    @(negedge clk);
    rd_strobe = 1'b0; op_done = 1'b0;
    check("R7 same cycle", rd_data, 16'h5A5A);
    check("R6 ready after", DW'(ready_o), DW'(1));
  endtask

  task automatic t_restart_ignored();
    start_op(1'b0, 16'h0000);
    do_read(16'hFFFF);
    check("R8 first", rd_data, 16'h00C0);
    start_op(1'b1, 16'hFFFF);
    do_read(16'hFFFF);
    check("R8 restart ignored", rd_data, 16'h0080);
    finish_op();
  endtask

  task automatic t_reset_mid();
    start_op(1'b0, 16'h0080);
    do_read(16'hFFFF);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R9 ready", DW'(ready_o), DW'(1));
    check("R9 cleared", rd_data, '0);
    do_read(16'h7777);
    check("R9 array after", rd_data, 16'h7777);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_read();
    t_program_hi();
    t_program_lo();
    t_erase();
    t_done_same_cycle();
    t_restart_ignored();
    t_reset_mid();
    idle(2);
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!ended) begin
      ended = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule